// File: doc/BRIEF.md
# Memory Access Fault Checker

This block sits beside a load/store unit and decides, one cycle after an access or a bus error report, whether a hardware exception must be requested. It watches three fault sources: misaligned data accesses (address bits that a halfword or word access forbids), stack bound violations (an address outside an inclusive low/high window), and failed bus transactions reported by the memory system as either an instruction fetch or a data access.

For the fault that wins, the block presents the word to load into the exception address register and, where the fault kind calls for it, the word to load into the exception status register. It also raises a one-cycle exception request. Each source has its own gating: misalignment always records but only requests when exceptions are enabled. The stack check runs only when its enable is set. Bus errors do nothing unless exceptions are enabled, and their status and request further depend on a per-bus configuration bit.

The access and bus error inputs are plain qualified strobes. The checker accepts every strobe in the cycle it is presented, so there is no ready signal and no back-pressure; the upstream unit may issue one access per cycle.

Top module: `mfc_fault_chk`

## Requirements
- R1: An access with `acc_valid` high is misaligned when `acc_addr[1:0] & acc_size_mask` is nonzero; the mask is 0 for a byte, 1 for a halfword and 3 for a word, so byte accesses never misalign.
- R2: The status word for a misaligned access holds the misalign cause (default 1) in bits 4:0, `acc_dest` in bits 9:5, `acc_write` in bit 10, a one in bit 11 when the mask is 3, and zeros above.
- R3: A misaligned access always loads the address and status registers; `exc_req` pulses only when `exc_en` is 1.
- R4: With `stk_chk_en` high, an access whose address is below `stk_lo` or above `stk_hi` (unsigned, limits inclusive) loads the address, loads status with the stack cause (default 7) in bits 4:0, and requests an exception whatever `exc_en` is; with `stk_chk_en` low no stack fault is raised.
- R5: A bus error with `exc_en` low has no effect.
- R6: A bus error with `exc_en` high loads `berr_addr` into the address register; for a fetch (`berr_fetch`=1) with `ibus_exc_cfg` set, status gets cause 2 and an exception is requested; for a data access with `dbus_exc_cfg` set, status gets cause 3 and a request; with the matching configuration bit clear only the address is loaded.
- R7: When faults coincide, an enabled bus error wins over a misaligned access, which wins over a stack fault; losing faults leave no trace.
- R8: All outputs are registered and appear the cycle after the cause; `exc_req`, `ear_load` and `esr_load` are one-cycle pulses and `ear_data`/`esr_data` hold their last loaded value.
- R9: After reset all outputs are zero.
- R10: A cycle with neither an access nor a bus error produces no request and no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Data access presented this cycle |
| acc_addr | input | AW | Access address |
| acc_size_mask | input | 2 | Alignment mask: 0 byte, 1 halfword, 3 word |
| acc_write | input | 1 | Access is a store |
| acc_dest | input | 5 | Destination/source register number |
| stk_lo | input | AW | Lowest legal stack address |
| stk_hi | input | AW | Highest legal stack address |
| stk_chk_en | input | 1 | Enables the stack bound check |
| exc_en | input | 1 | Global exception enable |
| ibus_exc_cfg | input | 1 | Fetch bus errors raise exceptions |
| dbus_exc_cfg | input | 1 | Data bus errors raise exceptions |
| berr_valid | input | 1 | A bus transaction failed this cycle |
| berr_fetch | input | 1 | The failed transaction was an instruction fetch |
| berr_addr | input | AW | Address of the failed transaction |
| exc_req | output | 1 | One-cycle exception request |
| ear_load | output | 1 | Exception address register load strobe |
| ear_data | output | AW | Exception address register load data |
| esr_load | output | 1 | Exception status register load strobe |
| esr_data | output | 32 | Exception status register load data |

## Verification
A bus error report and a data access can arrive in the same cycle, and a single access can be both misaligned and outside the stack window. The bench drives both pairings in one cycle, including a bus error with exceptions disabled beside a misaligned access, and judges the result by which address and which cause code appear on the output the next cycle and whether the loser left any mark.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int ESR_W    = 32;
  localparam int CAUSE_W  = 5;
  localparam int CAUSE_LSB = 0;
  localparam int DEST_W   = 5;
  localparam int DEST_LSB = 5;
  localparam int WR_BIT   = 10;
  localparam int WORD_BIT = 11;

  // fault source slots, lower index has higher priority
  localparam int SRC_BUS   = 0;
  localparam int SRC_ALIGN = 1;
  localparam int SRC_STACK = 2;
  localparam int NUM_SRC   = 3;

  typedef struct packed {
    logic             hit;     // source claims the cycle
    logic             req;     // source asks for an exception
    logic             ld_esr;  // source writes the status word
    logic [ESR_W-1:0] esr;     // status word to load
  } fault_t;
endpackage

// File: rtl/mfc_align_chk.sv
module mfc_align_chk
  import mfc_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [CAUSE_W-1:0] CODE = 5'd1
) (
  input  logic              valid,
  input  logic [AW-1:0]     addr,
  input  logic [1:0]        size_mask,
  input  logic              write,
  input  logic [DEST_W-1:0] dest,
  input  logic              exc_en,
  output fault_t            flt
);
  logic misaligned;
  logic is_word;

  assign misaligned = (addr[1:0] & size_mask) != 2'b00;
  assign is_word    = (size_mask == 2'b11);

  always_comb begin
    flt        = '0;
    flt.hit    = valid && misaligned;
    flt.req    = flt.hit && exc_en;
    flt.ld_esr = flt.hit;
    flt.esr[CAUSE_LSB +: CAUSE_W] = CODE;
    flt.esr[DEST_LSB +: DEST_W]   = dest;
    flt.esr[WR_BIT]               = write;
    flt.esr[WORD_BIT]             = is_word;
  end
endmodule

// File: rtl/mfc_stack_chk.sv
module mfc_stack_chk
  import mfc_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [CAUSE_W-1:0] CODE = 5'd7
) (
  input  logic          valid,
  input  logic          chk_en,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output fault_t        flt
);
  logic below, above;

  assign below = addr < lo;
  assign above = addr > hi;

  always_comb begin
    flt        = '0;
    flt.hit    = valid && chk_en && (below || above);
    flt.req    = flt.hit;
    flt.ld_esr = flt.hit;
    flt.esr[CAUSE_LSB +: CAUSE_W] = CODE;
  end
endmodule

// File: rtl/mfc_bus_chk.sv
module mfc_bus_chk
  import mfc_pkg::*;
#(
  parameter logic [CAUSE_W-1:0] ICODE = 5'd2,
  parameter logic [CAUSE_W-1:0] DCODE = 5'd3
) (
  input  logic   valid,
  input  logic   fetch,
  input  logic   exc_en,
  input  logic   icfg,
  input  logic   dcfg,
  output fault_t flt
);
  logic reporting;

  assign reporting = fetch ? icfg : dcfg;

  always_comb begin
    flt        = '0;
    flt.hit    = valid && exc_en;
    flt.ld_esr = flt.hit && reporting;
    flt.req    = flt.ld_esr;
    flt.esr[CAUSE_LSB +: CAUSE_W] = fetch ? ICODE : DCODE;
  end
endmodule

// File: rtl/mfc_prio.sv
module mfc_prio
  import mfc_pkg::*;
#(
  parameter int N  = 3,
  parameter int AW = 32
) (
  input  fault_t [N-1:0]         src,
  input  logic   [N-1:0][AW-1:0] src_addr,
  output logic                   any,
  output fault_t                 win,
  output logic   [AW-1:0]        win_addr
);
  always_comb begin
    any      = 1'b0;
    win      = '0;
    win_addr = '0;
    // walk from lowest priority up so the highest one overwrites
    for (int i = N - 1; i >= 0; i--) begin
      if (src[i].hit) begin
        any      = 1'b1;
        win      = src[i];
        win_addr = src_addr[i];
      end
    end
  end
endmodule

// File: rtl/mfc_fault_chk.sv
module mfc_fault_chk
  import mfc_pkg::*;
#(
  parameter int AW = 32,
  parameter bit HAS_STACK = 1'b1,
  parameter logic [CAUSE_W-1:0] ALIGN_CODE = 5'd1,
  parameter logic [CAUSE_W-1:0] IBUS_CODE  = 5'd2,
  parameter logic [CAUSE_W-1:0] DBUS_CODE  = 5'd3,
  parameter logic [CAUSE_W-1:0] STACK_CODE = 5'd7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [AW-1:0]    acc_addr,
  input  logic [1:0]       acc_size_mask,
  input  logic             acc_write,
  input  logic [4:0]       acc_dest,
  input  logic [AW-1:0]    stk_lo,
  input  logic [AW-1:0]    stk_hi,
  input  logic             stk_chk_en,
  input  logic             exc_en,
  input  logic             ibus_exc_cfg,
  input  logic             dbus_exc_cfg,
  input  logic             berr_valid,
  input  logic             berr_fetch,
  input  logic [AW-1:0]    berr_addr,
  output logic             exc_req,
  output logic             ear_load,
  output logic [AW-1:0]    ear_data,
  output logic             esr_load,
  output logic [ESR_W-1:0] esr_data
);
  fault_t [NUM_SRC-1:0]         flt;
  logic   [NUM_SRC-1:0][AW-1:0] flt_addr;
  fault_t                       win;
  logic   [AW-1:0]              win_addr;
  logic                         any;

  mfc_bus_chk #(.ICODE(IBUS_CODE), .DCODE(DBUS_CODE)) u_bus (
    .valid (berr_valid),
    .fetch (berr_fetch),
    .exc_en(exc_en),
    .icfg  (ibus_exc_cfg),
    .dcfg  (dbus_exc_cfg),
    .flt   (flt[SRC_BUS])
  );
  assign flt_addr[SRC_BUS] = berr_addr;

  mfc_align_chk #(.AW(AW), .CODE(ALIGN_CODE)) u_align (
    .valid    (acc_valid),
    .addr     (acc_addr),
    .size_mask(acc_size_mask),
    .write    (acc_write),
    .dest     (acc_dest),
    .exc_en   (exc_en),
    .flt      (flt[SRC_ALIGN])
  );
  assign flt_addr[SRC_ALIGN] = acc_addr;

  generate
    if (HAS_STACK) begin : g_stack
      mfc_stack_chk #(.AW(AW), .CODE(STACK_CODE)) u_stack (
        .valid (acc_valid),
        .chk_en(stk_chk_en),
        .addr  (acc_addr),
        .lo    (stk_lo),
        .hi    (stk_hi),
        .flt   (flt[SRC_STACK])
      );
    end else begin : g_no_stack
      assign flt[SRC_STACK] = '0;
    end
  endgenerate
  assign flt_addr[SRC_STACK] = acc_addr;

  mfc_prio #(.N(NUM_SRC), .AW(AW)) u_prio (
    .src     (flt),
    .src_addr(flt_addr),
    .any     (any),
    .win     (win),
    .win_addr(win_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_req  <= 1'b0;
      ear_load <= 1'b0;
      esr_load <= 1'b0;
      ear_data <= '0;
      esr_data <= '0;
    end else begin
      exc_req  <= any && win.req;
      ear_load <= any;
      esr_load <= any && win.ld_esr;
      if (any) ear_data <= win_addr;
      if (any && win.ld_esr) esr_data <= win.esr;
    end
  end
endmodule

// File: rtl/mfc_fault_sva.sv
module mfc_fault_sva #(
  parameter int AW = 32,
  parameter logic [4:0] STACK_CODE = 5'd7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input logic [1:0]    acc_size_mask,
  input logic [AW-1:0] stk_lo,
  input logic          stk_chk_en,
  input logic          exc_en,
  input logic          berr_valid,
  input logic [AW-1:0] berr_addr,
  input logic          exc_req,
  input logic          ear_load,
  input logic [AW-1:0] ear_data,
  input logic          esr_load,
  input logic [31:0]   esr_data
);
  logic mis;
  assign mis = (acc_addr[1:0] & acc_size_mask) != 2'b00;

  AST_REQ_WITH_EAR: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> ear_load); // R8
  AST_ESR_WITH_EAR: assert property (@(posedge clk) disable iff (!rst_n)
    esr_load |-> ear_load); // R8
  AST_EAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !ear_load && $past(rst_n)) |-> $stable(ear_data)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !berr_valid) |=> (!exc_req && !ear_load && !esr_load)); // R10
  AST_BUS_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_valid && !exc_en && !acc_valid) |=> !ear_load); // R5
  AST_BUS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_valid && exc_en) |=> (ear_load && ear_data == $past(berr_addr))); // R7
  AST_MIS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mis && !(berr_valid && exc_en)) |=>
      (ear_load && esr_load && ear_data == $past(acc_addr))); // R3
  AST_MIS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mis && !exc_en && !berr_valid) |=> !exc_req); // R3
  AST_STACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !mis && stk_chk_en && !berr_valid && (acc_addr < stk_lo)) |=>
      (exc_req && esr_data[4:0] == STACK_CODE)); // R4
endmodule

bind mfc_fault_chk mfc_fault_sva #(.AW(AW), .STACK_CODE(STACK_CODE)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid    (acc_valid),
  .acc_addr     (acc_addr),
  .acc_size_mask(acc_size_mask),
  .stk_lo       (stk_lo),
  .stk_chk_en   (stk_chk_en),
  .exc_en       (exc_en),
  .berr_valid   (berr_valid),
  .berr_addr    (berr_addr),
  .exc_req      (exc_req),
  .ear_load     (ear_load),
  .ear_data     (ear_data),
  .esr_load     (esr_load),
  .esr_data     (esr_data)
);

// File: tb/mfc_fault_chk_test.sv
module mfc_fault_chk_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 0;
  logic [31:0] acc_addr = 0;
  logic [1:0]  acc_size_mask = 0;
  logic        acc_write = 0;
  logic [4:0]  acc_dest = 0;
  logic [31:0] stk_lo = 32'h1000;
  logic [31:0] stk_hi = 32'h1FFF;
  logic        stk_chk_en = 0;
  logic        exc_en = 0;
  logic        ibus_exc_cfg = 0;
  logic        dbus_exc_cfg = 0;
  logic        berr_valid = 0;
  logic        berr_fetch = 0;
  logic [31:0] berr_addr = 0;
  logic        exc_req, ear_load, esr_load;
  logic [31:0] ear_data, esr_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mfc_fault_chk uut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size_mask(acc_size_mask),
    .acc_write(acc_write), .acc_dest(acc_dest),
    .stk_lo(stk_lo), .stk_hi(stk_hi), .stk_chk_en(stk_chk_en),
    .exc_en(exc_en), .ibus_exc_cfg(ibus_exc_cfg), .dbus_exc_cfg(dbus_exc_cfg),
    .berr_valid(berr_valid), .berr_fetch(berr_fetch), .berr_addr(berr_addr),
    .exc_req(exc_req), .ear_load(ear_load), .ear_data(ear_data),
    .esr_load(esr_load), .esr_data(esr_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // check the three strobes at once
  task automatic chk_strb(input string tag, input bit rq, input bit el, input bit sl);
    chk({tag, " exc_req"}, {31'd0, exc_req}, {31'd0, rq});
    chk({tag, " ear_load"}, {31'd0, ear_load}, {31'd0, el});
    chk({tag, " esr_load"}, {31'd0, esr_load}, {31'd0, sl});
  endtask

  task automatic clear_in();
    acc_valid = 0; berr_valid = 0;
  endtask

  // drive at a falling edge, the design registers on the next rising edge,
  // results are sampled at the following falling edge
  task automatic run_cycle(input bit av, input logic [31:0] a, input logic [1:0] m,
                           input bit w, input logic [4:0] d,
                           input bit bv, input bit bf, input logic [31:0] ba);
    @(negedge clk);
    acc_valid = av; acc_addr = a; acc_size_mask = m; acc_write = w; acc_dest = d;
    berr_valid = bv; berr_fetch = bf; berr_addr = ba;
    @(negedge clk);
    clear_in();
  endtask

  task automatic t_reset();
    chk_strb("R9 reset", 0, 0, 0);
    chk("R9 ear_data reset", ear_data, 32'h0);
    chk("R9 esr_data reset", esr_data, 32'h0);
  endtask

  task automatic t_aligned();
    exc_en = 1;
    run_cycle(1, 32'h0000_2004, 2'd3, 0, 5'd4, 0, 0, 0);
    chk_strb("R1 aligned word", 0, 0, 0);
    run_cycle(1, 32'h0000_2002, 2'd1, 0, 5'd4, 0, 0, 0);
    chk_strb("R1 aligned half", 0, 0, 0);
    run_cycle(1, 32'h0000_2003, 2'd0, 1, 5'd4, 0, 0, 0);
    chk_strb("R1 byte odd addr", 0, 0, 0);
  endtask

  task automatic t_misalign();
    exc_en = 1;
    run_cycle(1, 32'h0000_1001, 2'd1, 0, 5'd7, 0, 0, 0);
    chk_strb("R3 half mis en", 1, 1, 1);
    chk("R3 ear half", ear_data, 32'h0000_1001);
    chk("R2 esr half read", esr_data, 32'h0000_00E1);
    exc_en = 0;
    run_cycle(1, 32'h0000_2002, 2'd3, 1, 5'd31, 0, 0, 0);
    chk_strb("R3 word mis disabled", 0, 1, 1);
    chk("R3 ear word", ear_data, 32'h0000_2002);
    chk("R2 esr word write", esr_data, 32'h0000_0FE1);
    @(negedge clk);
    chk_strb("R8 pulse ends", 0, 0, 0);
    chk("R8 ear holds", ear_data, 32'h0000_2002);
    chk("R8 esr holds", esr_data, 32'h0000_0FE1);
  endtask

  task automatic t_stack();
    exc_en = 0; stk_chk_en = 1;
    run_cycle(1, 32'h0000_0FFC, 2'd3, 0, 5'd1, 0, 0, 0);
    chk_strb("R4 below low", 1, 1, 1);
    chk("R4 esr stack", esr_data, 32'h7);
    chk("R4 ear stack", ear_data, 32'h0000_0FFC);
    run_cycle(1, 32'h0000_2000, 2'd3, 0, 5'd1, 0, 0, 0);
    chk_strb("R4 above high", 1, 1, 1);
    run_cycle(1, 32'h0000_1000, 2'd3, 0, 5'd1, 0, 0, 0);
    chk_strb("R4 at low limit", 0, 0, 0);
    run_cycle(1, 32'h0000_1FFF, 2'd0, 0, 5'd1, 0, 0, 0);
    chk_strb("R4 at high limit", 0, 0, 0);
    stk_chk_en = 0;
    run_cycle(1, 32'h0000_0FFC, 2'd3, 0, 5'd1, 0, 0, 0);
    chk_strb("R4 check disabled", 0, 0, 0);
  endtask

  task automatic t_bus();
    exc_en = 1; ibus_exc_cfg = 1; dbus_exc_cfg = 1;
    run_cycle(0, 0, 0, 0, 0, 1, 1, 32'h0000_ABC0);
    chk_strb("R6 fetch error", 1, 1, 1);
    chk("R6 fetch esr", esr_data, 32'h2);
    chk("R6 fetch ear", ear_data, 32'h0000_ABC0);
    run_cycle(0, 0, 0, 0, 0, 1, 0, 32'h0000_DEF4);
    chk_strb("R6 data error", 1, 1, 1);
    chk("R6 data esr", esr_data, 32'h3);
    ibus_exc_cfg = 0;
    run_cycle(0, 0, 0, 0, 0, 1, 1, 32'h0000_5550);
    chk_strb("R6 fetch cfg off", 0, 1, 0);
    chk("R6 cfg off ear", ear_data, 32'h0000_5550);
    chk("R6 cfg off esr kept", esr_data, 32'h3);
    exc_en = 0; ibus_exc_cfg = 1;
    run_cycle(0, 0, 0, 0, 0, 1, 0, 32'h0000_7770);
    chk_strb("R5 bus muted", 0, 0, 0);
    chk("R5 ear untouched", ear_data, 32'h0000_5550);
  endtask

  task automatic t_prio();
    exc_en = 1; dbus_exc_cfg = 1; stk_chk_en = 1;
    run_cycle(1, 32'h0000_1001, 2'd1, 0, 5'd2, 1, 0, 32'h0000_3330);
    chk_strb("R7 bus over misalign", 1, 1, 1);
    chk("R7 bus ear", ear_data, 32'h0000_3330);
    chk("R7 bus esr", esr_data, 32'h3);
    run_cycle(1, 32'h0000_0FFD, 2'd1, 0, 5'd2, 0, 0, 0);
    chk("R7 misalign over stack ear", ear_data, 32'h0000_0FFD);
    chk("R7 misalign over stack esr", esr_data, 32'h0000_0041);
    exc_en = 0;
    run_cycle(1, 32'h0000_1003, 2'd3, 1, 5'd3, 1, 0, 32'h0000_4440);
    chk_strb("R7 muted bus lets misalign", 0, 1, 1);
    chk("R7 muted bus ear", ear_data, 32'h0000_1003);
    chk("R7 muted bus esr", esr_data, 32'h0000_0C61);
    stk_chk_en = 0;
  endtask

  task automatic t_idle();
    exc_en = 1;
    @(negedge clk);
    @(negedge clk);
    chk_strb("R10 idle", 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_misalign();
    t_stack();
    t_bus();
    t_prio();
    t_idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule